// File: doc/BRIEF.md
# Repeat-Mode Calendar Alarm Comparator

This block watches the running calendar of a real-time clock and decides, once per one-second tick, whether the programmed alarm time has been reached. The calendar (date, hours, minutes, seconds) and the programmed alarm fields arrive as BCD bytes. A five-bit repeat code chooses which fields must agree. The code can ask for a match on every second, on seconds only, on minutes and seconds, on hours down to seconds, or on date down to seconds. Any code outside that set behaves as once per second, so a wrong setting shows up quickly.

When a match is found, the block sets an alarm flag and may pull an open-drain interrupt pin low. In normal operation the pin is pulled only when the flag enable is set. While the system runs on backup power, the pin is pulled only when the backup-alarm enable and the flag enable are both set. A read of the flags register is presented as a one-cycle strobe. The first read after an interrupt releases the pin, and the next read clears the flag. Both enables come from a register file that clears them at power-up. An alarm that arrives during power-up therefore sets only the flag.

Top module: `rtc_alarm_match`

## Requirements
- R1: A match is evaluated only in a clock cycle where `sec_tick` is 1. The flag is 1 after the rising clock edge that samples that tick. Without a tick the flag never sets, even when all fields agree.
- R2: Repeat code 5'b11111 (bit 4 is repeat bit 5, bit 0 is repeat bit 1) sets the flag on every tick, whatever the field values are.
- R3: Each code includes its own set of fields in the match. Code 5'b11110 compares seconds. Code 5'b11100 compares minutes and seconds. Code 5'b11000 compares hours, minutes and seconds. Code 5'b10000 compares date, hours, minutes and seconds. The flag sets on a tick only if every included field is equal.
- R4: Every other repeat code sets the flag on every tick, the same as 5'b11111.
- R5: Outside backup mode, a match drives `irq_drive`=1 and `irq_n`=0 only when `flag_en` is 1.
- R6: In backup mode (`on_backup`=1), the pin may be driven only when `bkup_en` and `flag_en` are both 1. Otherwise a match sets only the flag.
- R7: With both enables at 0, a match sets the flag and leaves the pin released (`irq_drive`=0, `irq_n`=1).
- R8: A flags read while the pin is latched active releases the pin and keeps the flag. A flags read while no interrupt is latched clears the flag.
- R9: If a tick match and a flags read fall in the same cycle, the new alarm wins. The flag stays 1, and the interrupt is latched again if the enables permit.
- R10: Code 5'b10000 with an alarm date of 8'h00 never sets the flag, because a calendar date is never zero. This is how the alarm is disabled.
- R11: After reset the flag is 0 and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| cur_date | input | 8 | Running date, BCD |
| cur_hour | input | 8 | Running hours, BCD |
| cur_min | input | 8 | Running minutes, BCD |
| cur_sec | input | 8 | Running seconds, BCD |
| alm_date | input | 8 | Alarm date, BCD |
| alm_hour | input | 8 | Alarm hours, BCD |
| alm_min | input | 8 | Alarm minutes, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD |
| rpt_code | input | 5 | Repeat code; bit 4 is repeat bit 5 |
| flag_en | input | 1 | Alarm flag enable toward the pin |
| bkup_en | input | 1 | Permits the pin while on backup power |
| on_backup | input | 1 | System is running on backup power |
| flags_rd | input | 1 | One-cycle strobe for a flags-register read |
| alarm_flag | output | 1 | Alarm flag |
| irq_drive | output | 1 | 1 = pull the open-drain interrupt pin low |
| irq_n | output | 1 | Pin level seen with the pull-up: 0 when driven |

## Verification
The assertions check, on every cycle, the rules that hold at all times. The pin is never driven without the flag. It stays released whenever the active gating forbids it. The flag only rises right after a tick. A read that releases the pin leaves the flag intact. The decoded field mask is always a contiguous run from the seconds field upward.

The bench's scenarios are needed to show that each repeat code selects exactly its own fields and that illegal codes fall back to once per second. They also show the two-read release-then-clear order, that an alarm beats a read in the same cycle, and that a zero alarm date with code 5'b10000 never fires.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned RPT_W      = NUM_FIELDS + 1;

  typedef logic [NUM_FIELDS-1:0]         fld_mask_t;
  typedef logic [NUM_FIELDS*FIELD_W-1:0] cal_vec_t;
endpackage

// File: rtl/rtc_alarm_rpt_decode.sv
module rtc_alarm_rpt_decode #(
  parameter int unsigned NUM_FIELDS = rtc_alarm_pkg::NUM_FIELDS,
  localparam int unsigned RPT_W     = NUM_FIELDS + 1
) (
  input  logic [RPT_W-1:0]      rpt_code,
  output logic [NUM_FIELDS-1:0] fld_mask,
  output logic                  code_legal
);
  // Legal codes: top bit 1, lower bits all ones down to a run of zeros from
  // the LSB side. The zeros mark fields that join the compare (seconds first).
  logic [NUM_FIELDS-1:0] inv_low;
  logic [NUM_FIELDS-1:0] inv_inc;

  always_comb begin
    inv_low    = ~rpt_code[NUM_FIELDS-1:0];
    inv_inc    = inv_low + 1'b1;
    code_legal = rpt_code[RPT_W-1] && ((inv_low & inv_inc) == '0);
    fld_mask   = code_legal ? inv_low : '0;
  end
endmodule

// File: rtl/rtc_alarm_field_cmp.sv
module rtc_alarm_field_cmp #(
  parameter int unsigned FIELD_W    = rtc_alarm_pkg::FIELD_W,
  parameter int unsigned NUM_FIELDS = rtc_alarm_pkg::NUM_FIELDS,
  localparam int unsigned VEC_W     = FIELD_W * NUM_FIELDS
) (
  input  logic [VEC_W-1:0]      cur_vec,
  input  logic [VEC_W-1:0]      alm_vec,
  input  logic [NUM_FIELDS-1:0] fld_mask,
  output logic                  all_match
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    always_comb begin
      fld_ok[g] = !fld_mask[g] ||
                  (cur_vec[g*FIELD_W +: FIELD_W] == alm_vec[g*FIELD_W +: FIELD_W]);
    end
  end

  always_comb all_match = &fld_ok;
endmodule

// File: rtl/rtc_alarm_flag_ctl.sv
module rtc_alarm_flag_ctl (
  input  logic clk,
  input  logic rst_n_sync,
  input  logic hit,
  input  logic rd_strobe,
  input  logic pin_allow,
  output logic flag_q,
  output logic latch_q
);
  logic flag_d;
  logic latch_d;
  logic upd_en;

  always_comb begin
    flag_d  = flag_q;
    latch_d = latch_q;
    upd_en  = hit || rd_strobe;
    if (hit) begin
      flag_d = 1'b1;
      if (pin_allow) latch_d = 1'b1;
    end else if (rd_strobe) begin
      if (latch_q) latch_d = 1'b0;
      else         flag_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      flag_q  <= 1'b0;
      latch_q <= 1'b0;
    end else if (upd_en) begin
      flag_q  <= flag_d;
      latch_q <= latch_d;
    end
  end

  AST_LATCH_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    latch_q |-> flag_q); // R8
  AST_RELEASE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_strobe && !hit && latch_q) |=> (flag_q && !latch_q)); // R8
  AST_HIT_WINS_READ: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (hit && rd_strobe) |=> flag_q); // R9
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned FIELD_W    = rtc_alarm_pkg::FIELD_W,
  parameter int unsigned NUM_FIELDS = rtc_alarm_pkg::NUM_FIELDS,
  localparam int unsigned RPT_W     = NUM_FIELDS + 1,
  localparam int unsigned VEC_W     = FIELD_W * NUM_FIELDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] alm_date,
  input  logic [FIELD_W-1:0] alm_hour,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic [RPT_W-1:0]   rpt_code,
  input  logic               flag_en,
  input  logic               bkup_en,
  input  logic               on_backup,
  input  logic               flags_rd,
  output logic               alarm_flag,
  output logic               irq_drive,
  output logic               irq_n
);
  logic                  rst_meta;
  logic                  rst_n_sync;
  logic [VEC_W-1:0]      cur_vec;
  logic [VEC_W-1:0]      alm_vec;
  logic [NUM_FIELDS-1:0] fld_mask;
  logic                  code_legal;
  logic                  all_match;
  logic                  hit;
  logic                  pin_allow;
  logic                  latch_q;

  // Reset asserts at once, deasserts on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  // Field 0 is seconds; higher indices are coarser units.
  always_comb begin
    cur_vec = {cur_date, cur_hour, cur_min, cur_sec};
    alm_vec = {alm_date, alm_hour, alm_min, alm_sec};
  end

  rtc_alarm_rpt_decode #(.NUM_FIELDS(NUM_FIELDS)) u_dec (
    .rpt_code   (rpt_code),
    .fld_mask   (fld_mask),
    .code_legal (code_legal)
  );

  rtc_alarm_field_cmp #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_cmp (
    .cur_vec   (cur_vec),
    .alm_vec   (alm_vec),
    .fld_mask  (fld_mask),
    .all_match (all_match)
  );

  always_comb begin
    hit       = sec_tick && all_match;
    pin_allow = on_backup ? (flag_en && bkup_en) : flag_en;
  end

  rtc_alarm_flag_ctl u_ctl (
    .clk        (clk),
    .rst_n_sync (rst_n_sync),
    .hit        (hit),
    .rd_strobe  (flags_rd),
    .pin_allow  (pin_allow),
    .flag_q     (alarm_flag),
    .latch_q    (latch_q)
  );

  always_comb begin
    irq_drive = latch_q && pin_allow;
    irq_n     = !irq_drive;
  end

  AST_FLAG_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(alarm_flag) |-> $past(sec_tick)); // R1
  AST_PIN_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq_drive |-> alarm_flag); // R5
  AST_NORMAL_GATE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!on_backup && !flag_en) |-> irq_n); // R7
  AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (on_backup && !(bkup_en && flag_en)) |-> !irq_drive); // R6
  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((fld_mask & (fld_mask + 1'b1)) == '0)); // R3
  AST_ILLEGAL_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !code_legal |-> (all_match == 1'b1)); // R4
endmodule

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_tick, flag_en, bkup_en, on_backup, flags_rd;
  logic [7:0] cur_date, cur_hour, cur_min, cur_sec;
  logic [7:0] alm_date, alm_hour, alm_min, alm_sec;
  logic [4:0] rpt_code;
  logic       alarm_flag, irq_drive, irq_n;

  int checks = 0;
  int errors = 0;
  bit m_flag  = 1'b0;
  bit m_latch = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_match dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_date(cur_date), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_date(alm_date), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
    .rpt_code(rpt_code), .flag_en(flag_en), .bkup_en(bkup_en), .on_backup(on_backup),
    .flags_rd(flags_rd), .alarm_flag(alarm_flag), .irq_drive(irq_drive), .irq_n(irq_n)
  );

  // Fields compared per code: bit0 sec, bit1 min, bit2 hour, bit3 date.
  function automatic logic [3:0] f_fields(input logic [4:0] c);
    case (c)
      5'b11110: return 4'b0001;
      5'b11100: return 4'b0011;
      5'b11000: return 4'b0111;
      5'b10000: return 4'b1111;
      default:  return 4'b0000;
    endcase
  endfunction

  function automatic bit f_match();
    logic [3:0] m;
    m = f_fields(rpt_code);
    return (!m[0] || cur_sec  == alm_sec)  && (!m[1] || cur_min  == alm_min) &&
           (!m[2] || cur_hour == alm_hour) && (!m[3] || cur_date == alm_date);
  endfunction

  function automatic bit f_allow();
    return on_backup ? (flag_en && bkup_en) : flag_en;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    bit hit;
    @(posedge clk);
    hit = sec_tick && f_match();
    if (hit) begin
      m_flag = 1'b1;
      if (f_allow()) m_latch = 1'b1;
    end else if (flags_rd) begin
      if (m_latch) m_latch = 1'b0;
      else         m_flag  = 1'b0;
    end
    #2;
    chk(tag, "alarm_flag", int'(alarm_flag), int'(m_flag));
    chk(tag, "irq_drive", int'(irq_drive), int'(m_latch && f_allow()));
    chk(tag, "irq_n", int'(irq_n), int'(!(m_latch && f_allow())));
    @(negedge clk);
    sec_tick = 1'b0;
    flags_rd = 1'b0;
  endtask

  task automatic set_cur(input logic [7:0] d, h, m, s);
    cur_date = d; cur_hour = h; cur_min = m; cur_sec = s;
  endtask

  task automatic set_alm(input logic [7:0] d, h, m, s);
    alm_date = d; alm_hour = h; alm_min = m; alm_sec = s;
  endtask

  task automatic tick(input string tag);
    sec_tick = 1'b1;
    cycle(tag);
  endtask

  task automatic rd(input string tag);
    flags_rd = 1'b1;
    cycle(tag);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_tick = 0; flags_rd = 0; flag_en = 0; bkup_en = 0; on_backup = 0;
    rpt_code = 5'b11111;
    set_cur(8'h01, 8'h00, 8'h00, 8'h00);
    set_alm(8'h02, 8'h03, 8'h04, 8'h05);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11", "alarm_flag", int'(alarm_flag), 0);
    chk("R11", "irq_n", int'(irq_n), 1);

    // R1 no tick: full agreement but no evaluation
    rpt_code = 5'b11110; set_alm(8'h01, 8'h00, 8'h00, 8'h00);
    cycle("R1");
    chk("R1", "flag without tick", int'(alarm_flag), 0);

    // R2 every second even with mismatch; R7 pin stays released
    rpt_code = 5'b11111; set_alm(8'h09, 8'h09, 8'h09, 8'h09);
    tick("R2");
    chk("R2", "flag", int'(alarm_flag), 1);
    chk("R7", "pin released", int'(irq_n), 1);
    rd("R8");
    chk("R8", "read clears unlatched flag", int'(alarm_flag), 0);

    // R3 minutes+seconds
    rpt_code = 5'b11100;
    set_cur(8'h01, 8'h10, 8'h22, 8'h33); set_alm(8'h05, 8'h11, 8'h21, 8'h33);
    tick("R3");
    chk("R3", "minute mismatch", int'(alarm_flag), 0);
    alm_min = 8'h22;
    tick("R3");
    chk("R3", "min+sec match", int'(alarm_flag), 1);
    rd("R3");
    rpt_code = 5'b11000;
    tick("R3");
    chk("R3", "hour mismatch", int'(alarm_flag), 0);
    rpt_code = 5'b11110; alm_sec = 8'h34;
    tick("R3");
    chk("R3", "second mismatch", int'(alarm_flag), 0);

    // R4 illegal code fires regardless
    rpt_code = 5'b01010;
    tick("R4");
    chk("R4", "illegal code fires", int'(alarm_flag), 1);
    rd("R4");
    rpt_code = 5'b11010;
    tick("R4");
    rd("R4");

    // R5 pin with enable, then release-then-clear order (R8)
    flag_en = 1; rpt_code = 5'b11111;
    tick("R5");
    chk("R5", "irq_n low", int'(irq_n), 0);
    rd("R8");
    chk("R8", "pin released", int'(irq_drive), 0);
    chk("R8", "flag kept", int'(alarm_flag), 1);
    rd("R8");
    chk("R8", "flag cleared", int'(alarm_flag), 0);

    // R6 backup gating
    on_backup = 1; bkup_en = 0;
    tick("R6");
    chk("R6", "pin blocked", int'(irq_drive), 0);
    chk("R6", "flag set", int'(alarm_flag), 1);
    rd("R6");
    bkup_en = 1;
    tick("R6");
    chk("R6", "pin driven", int'(irq_drive), 1);

    // R9 hit and read in same cycle
    sec_tick = 1; flags_rd = 1;
    cycle("R9");
    chk("R9", "flag", int'(alarm_flag), 1);
    chk("R9", "pin", int'(irq_drive), 1);
    rd("R9"); rd("R9");
    on_backup = 0; bkup_en = 0;

    // R10 disable via zero date
    rpt_code = 5'b10000; set_alm(8'h00, 8'h10, 8'h22, 8'h33);
    tick("R10");
    chk("R10", "disabled alarm", int'(alarm_flag), 0);

    // Random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] codes [6];
      codes = '{5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000, 5'b00000};
      rpt_code = ($urandom % 8 == 0) ? 5'($urandom) : codes[$urandom % 5];
      set_cur(8'($urandom % 2 + 1), 8'($urandom % 2), 8'($urandom % 2), 8'($urandom % 2));
      set_alm(8'($urandom % 3), 8'($urandom % 2), 8'($urandom % 2), 8'($urandom % 2));
      flag_en   = 1'($urandom);
      bkup_en   = 1'($urandom);
      on_backup = ($urandom % 4 == 0);
      sec_tick  = ($urandom % 3 == 0);
      flags_rd  = ($urandom % 3 == 0);
      cycle("R3");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule